// File: doc/BRIEF.md
# Serial Register Access Port

This block is a serial slave that lets an external host read and write a bank of 32 eight-bit control registers. The host holds an active-low frame line low for the whole transaction, toggles a serial clock and moves data on a shared data line. Each frame opens with an 8-bit instruction header. The header gives the transfer direction, a byte count and a starting register address. One to four data bytes follow, and the register address counts down after each byte.

Read data can leave the block on one of two pins. In 3-wire mode it goes out on the shared data line. In 4-wire mode it goes out on a separate output line. A static mode input selects between the two. The shared line is modelled as separate input, output and output-enable signals.

All serial inputs pass through a synchronizer into the system clock domain. The block detects serial clock edges there. Every output comes from a register.

Top module: `serreg_port`

## Requirements
- R1: After reset every register reads 0x00, and both output enables (`sdio_oe`, `sdo_oe`) are low.
- R2: The 8-bit header is sampled on rising serial clock edges in this order: direction bit first (1 = read, 0 = write), then a 2-bit byte count (high bit first), then address bits A4 down to A0.
- R3: A write frame stores each complete 8-bit data byte at the current address. Data is sampled on rising serial clock edges, most significant bit first.
- R4: The byte count field `c` selects `c`+1 bytes (00 = 1 byte, 11 = 4 bytes). After each byte the address decrements modulo 32, so address 0 is followed by address 31.
- R5: A read frame drives the addressed register on falling serial clock edges, most significant bit first, beginning with the first falling edge after the last header bit. The address counts down as in R4.
- R6: In 3-wire mode (`four_wire` = 0), read data appears on `sdio_out` with `sdio_oe` high, and `sdo_oe` stays low for the whole frame.
- R7: In 4-wire mode (`four_wire` = 1), read data appears on `sdo_out` with `sdo_oe` high, and `sdio_oe` stays low for the whole frame.
- R8: If the frame line rises before a data byte is complete, that partial byte is discarded. The addressed register keeps its value.
- R9: Data bytes sent after the header's byte count is used up are ignored, and no register changes.
- R10: Both output enables stay low during the header and while no frame is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| four_wire | input | 1 | Static mode: 1 sends read data on `sdo_out`, 0 on `sdio_out` |
| frame_n | input | 1 | Active-low frame enable from the host |
| sck | input | 1 | Serial clock from the host |
| sdio_in | input | 1 | Input half of the shared data line |
| sdio_out | output | 1 | Output half of the shared data line |
| sdio_oe | output | 1 | Drive enable for the shared data line |
| sdo_out | output | 1 | Separate serial data output |
| sdo_oe | output | 1 | Drive enable for the separate output |

## Verification
Each serial input passes through two synchronizer flops. One more register then acts on the detected edge. A read bit or an enable change therefore shows at the outputs three system clocks after the serial clock edge that causes it. A completed write byte reaches the register bank two clocks after that. The bench holds every serial clock level for eight system clocks. It samples read bits and enables at the host's next rising serial clock edge, at least five clocks after the design has settled. Stored values are checked only by reading them back in a later frame.

// File: rtl/serreg_pkg.sv
package serreg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_DATA = 2'd2,
    ST_DONE = 2'd3
  } frame_state_t;
endpackage

// File: rtl/serreg_sync.sv
module serreg_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{RESET_VAL}};
      prev  <= RESET_VAL;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign dout = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~prev;
  assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/serreg_regfile.sv
module serreg_regfile #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdata <= '0;
    end else begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/serreg_port.sv
module serreg_port #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 5,
  parameter int CNT_W     = 2,
  parameter int SYNC_STGS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic four_wire,
  input  logic frame_n,
  input  logic sck,
  input  logic sdio_in,
  output logic sdio_out,
  output logic sdio_oe,
  output logic sdo_out,
  output logic sdo_oe
);
  import serreg_pkg::*;

  localparam int HDR_W = 1 + CNT_W + ADDR_W;
  localparam int MAX_W = (HDR_W > DATA_W) ? HDR_W : DATA_W;
  localparam int BC_W  = $clog2(MAX_W);

  logic frame_s, frame_rise_u, frame_fall_u;
  logic sck_s, sck_r, sck_f;
  logic sdi_s, sdi_rise_u, sdi_fall_u;

  serreg_sync #(.STAGES(SYNC_STGS), .RESET_VAL(1'b1)) u_sync_frame (
    .clk(clk), .rst(rst), .din(frame_n),
    .dout(frame_s), .rise(frame_rise_u), .fall(frame_fall_u)
  );
  serreg_sync #(.STAGES(SYNC_STGS), .RESET_VAL(1'b0)) u_sync_sck (
    .clk(clk), .rst(rst), .din(sck),
    .dout(sck_s), .rise(sck_r), .fall(sck_f)
  );
  serreg_sync #(.STAGES(SYNC_STGS), .RESET_VAL(1'b0)) u_sync_sdi (
    .clk(clk), .rst(rst), .din(sdio_in),
    .dout(sdi_s), .rise(sdi_rise_u), .fall(sdi_fall_u)
  );

  frame_state_t      state;
  logic [BC_W-1:0]   bitcnt;
  logic [HDR_W-2:0]  hdr_sh;
  logic [DATA_W-2:0] dat_sh;
  logic              dir_q;
  logic [CNT_W-1:0]  left_q;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rd_data;
  logic [DATA_W-1:0] rd_shift;
  logic [HDR_W-1:0]  hdr_full;
  logic              out_bit;
  logic              byte_end;

  assign hdr_full = {hdr_sh, sdi_s};
  assign rd_shift = rd_data << bitcnt;
  assign byte_end = (bitcnt == BC_W'(DATA_W - 1));

  serreg_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .we(we_q), .waddr(waddr_q), .wdata(wdata_q),
    .raddr(addr_q), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      hdr_sh  <= '0;
      dat_sh  <= '0;
      dir_q   <= 1'b0;
      left_q  <= '0;
      addr_q  <= '0;
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
      out_bit <= 1'b0;
      sdio_oe <= 1'b0;
      sdo_oe  <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (frame_s) begin
        state   <= ST_IDLE;
        sdio_oe <= 1'b0;
        sdo_oe  <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: begin
            state  <= ST_HDR;
            bitcnt <= '0;
          end
          ST_HDR: begin
            if (sck_r) begin
              hdr_sh <= hdr_full[HDR_W-2:0];
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == BC_W'(HDR_W - 1)) begin
                dir_q  <= hdr_full[HDR_W-1];
                left_q <= hdr_full[ADDR_W +: CNT_W];
                addr_q <= hdr_full[ADDR_W-1:0];
                bitcnt <= '0;
                state  <= ST_DATA;
              end
            end
          end
          ST_DATA: begin
            if (sck_f && dir_q) begin
              out_bit <= rd_shift[DATA_W-1];
              sdio_oe <= ~four_wire;
              sdo_oe  <= four_wire;
            end
            if (sck_r) begin
              dat_sh <= {dat_sh[DATA_W-3:0], sdi_s};
              bitcnt <= bitcnt + 1'b1;
              if (byte_end) begin
                bitcnt <= '0;
                addr_q <= addr_q - 1'b1;
                if (!dir_q) begin
                  we_q    <= 1'b1;
                  waddr_q <= addr_q;
                  wdata_q <= {dat_sh, sdi_s};
                end
                if (left_q == '0) state <= ST_DONE;
                else              left_q <= left_q - 1'b1;
              end
            end
          end
          default: begin
            if (sck_f) begin
              sdio_oe <= 1'b0;
              sdo_oe  <= 1'b0;
            end
          end
        endcase
      end
    end
  end

  assign sdio_out = out_bit;
  assign sdo_out  = out_bit;
endmodule

// File: rtl/serreg_port_chk.sv
module serreg_port_chk (
  input logic clk,
  input logic rst,
  input logic four_wire,
  input logic frame_n,
  input logic sdio_oe,
  input logic sdo_oe,
  input logic we_q,
  input logic dir_q
);
  AST_SDO_QUIET_3W: assert property (@(posedge clk) disable iff (rst)
    !four_wire |-> !sdo_oe); // R6
  AST_SDIO_QUIET_4W: assert property (@(posedge clk) disable iff (rst)
    four_wire |-> !sdio_oe); // R7
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (frame_n && $past(frame_n) && $past(frame_n, 2) && $past(frame_n, 3) && $past(frame_n, 4))
      |-> !(sdio_oe || sdo_oe)); // R10
  AST_WRITE_IN_WRITE_FRAME: assert property (@(posedge clk) disable iff (rst)
    we_q |-> !dir_q); // R3
  AST_DRIVE_IN_READ_FRAME: assert property (@(posedge clk) disable iff (rst)
    (sdio_oe || sdo_oe) |-> dir_q); // R5
endmodule

bind serreg_port serreg_port_chk u_chk (
  .clk(clk), .rst(rst), .four_wire(four_wire), .frame_n(frame_n),
  .sdio_oe(sdio_oe), .sdo_oe(sdo_oe), .we_q(we_q), .dir_q(dir_q)
);

// File: tb/serreg_port_tb.sv
module serreg_port_tb;
  localparam int HP = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic four_wire = 1'b0;
  logic frame_n = 1'b1;
  logic sck = 1'b0;
  logic sdio_in = 1'b0;
  logic sdio_out, sdio_oe, sdo_out, sdo_oe;

  int nchk = 0;
  int nfail = 0;

  logic [7:0] model [32];
  logic [7:0] exp_q [$];
  logic [7:0] wbuf [8];
  string      cur_req = "R5";
  bit         mon_arm = 1'b0;
  bit         hdr_quiet = 1'b0;
  logic [7:0] mon_sh = '0;
  int         mon_cnt = 0;

  always #5 clk = ~clk;

  serreg_port u_dut (
    .clk(clk), .rst(rst), .four_wire(four_wire), .frame_n(frame_n),
    .sck(sck), .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe),
    .sdo_out(sdo_out), .sdo_oe(sdo_oe)
  );

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic wait_hp();
    repeat (HP) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    sdio_in = b;
    wait_hp();
    sck = 1'b1;
    if (hdr_quiet) chk(!sdio_oe && !sdo_oe, "R10 header quiet", {sdio_oe, sdo_oe}, 0);
    wait_hp();
    sck = 1'b0;
  endtask

  task automatic send_hdr(input logic rd, input logic [1:0] n, input logic [4:0] a);
    logic [7:0] h;
    h = {rd, n, a};
    hdr_quiet = 1'b1;
    for (int i = 7; i >= 0; i--) shift_bit(h[i]);
    hdr_quiet = 1'b0;
  endtask

  task automatic frame_open();
    frame_n = 1'b0;
    wait_hp();
  endtask

  task automatic frame_close();
    wait_hp();
    frame_n = 1'b1;
    wait_hp();
    wait_hp();
    chk(!sdio_oe && !sdo_oe, "R10 idle quiet", {sdio_oe, sdo_oe}, 0);
  endtask

  task automatic wr(input logic [1:0] n, input logic [4:0] a, input int nbytes, input int tail_bits);
    frame_open();
    send_hdr(1'b0, n, a);
    for (int k = 0; k < nbytes; k++) begin
      for (int i = 7; i >= 0; i--) shift_bit(wbuf[k][i]);
      if (k <= int'(n)) model[5'(a - 5'(k))] = wbuf[k];
    end
    for (int i = 0; i < tail_bits; i++) shift_bit(i[0]);
    frame_close();
  endtask

  task automatic rd(input logic [1:0] n, input logic [4:0] a, input string req);
    cur_req = req;
    frame_open();
    send_hdr(1'b1, n, a);
    for (int k = 0; k <= int'(n); k++) begin
      exp_q.push_back(model[5'(a - 5'(k))]);
      mon_arm = 1'b1;
      for (int i = 0; i < 8; i++) shift_bit(1'b0);
    end
    mon_arm = 1'b0;
    frame_close();
    chk(exp_q.size() == 0, "R4 byte count", exp_q.size(), 0);
  endtask

  always @(posedge sck) begin
    if (mon_arm) begin
      if (four_wire) begin
        chk(sdo_oe && !sdio_oe, "R7 output enables", {sdio_oe, sdo_oe}, 1);
        mon_sh = {mon_sh[6:0], sdo_out};
      end else begin
        chk(sdio_oe && !sdo_oe, "R6 output enables", {sdio_oe, sdo_oe}, 2);
        mon_sh = {mon_sh[6:0], sdio_out};
      end
      mon_cnt++;
      if (mon_cnt == 8) begin
        mon_cnt = 0;
        if (exp_q.size() == 0) chk(1'b0, cur_req, mon_sh, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(mon_sh == e, cur_req, mon_sh, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(!sdio_oe && !sdo_oe, "R1 reset enables", {sdio_oe, sdo_oe}, 0);
    rd(2'b11, 5'd3, "R1 reset contents");

    // R3: single write, read back in 3-wire mode (R6)
    wbuf[0] = 8'hA5;
    wr(2'b00, 5'd5, 1, 0);
    rd(2'b00, 5'd5, "R3 single write");
    rd(2'b00, 5'd5, "R6 3-wire read");

    // R4: four-byte write wrapping 1,0,31,30; R7 read in 4-wire
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    wr(2'b11, 5'd1, 4, 0);
    four_wire = 1'b1;
    rd(2'b11, 5'd1, "R4 burst wrap");
    rd(2'b10, 5'd0, "R7 4-wire read");
    four_wire = 1'b0;
    rd(2'b01, 5'd31, "R5 read burst");

    // R8: partial byte discarded
    wr(2'b00, 5'd10, 0, 5);
    rd(2'b00, 5'd10, "R8 partial single");
    wbuf[0] = 8'h66;
    wr(2'b01, 5'd12, 1, 4);
    rd(2'b01, 5'd12, "R8 partial in burst");

    // R9: bytes beyond the count ignored
    wbuf[0] = 8'hC3; wbuf[1] = 8'h99;
    wr(2'b00, 5'd20, 2, 0);
    four_wire = 1'b1;
    rd(2'b01, 5'd20, "R9 extra byte ignored");
    four_wire = 1'b0;

    // R2: header bits with alternating patterns
    wbuf[0] = 8'h5A; wbuf[1] = 8'hF0; wbuf[2] = 8'h0F;
    wr(2'b10, 5'd21, 3, 0);
    rd(2'b10, 5'd21, "R2 header decode");
    rd(2'b00, 5'd19, "R2 mid address");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule